// File: doc/BRIEF.md
# Frequency-Keyed Triangle PWM Modulator

This block drives the two switches of a synchronous boost stage and, at the same time, sends bytes over the supply ripple by moving the switching frequency. A symmetric up/down counter forms a triangle carrier. The main switch is requested while the counter is below a threshold. The threshold is the commanded duty word scaled to the peak in use, so the duty ratio holds when the period changes. A frame machine wraps each byte in a low start bit and a high stop bit, sends the data least significant bit first, and selects one of two carrier peaks for every bit. The long peak (lower frequency) is used only for a 0 bit. Idle and 1 bits use the short peak (nominal frequency). At the defaults of a 60 MHz clock, peaks of 300 and 360 counts and 30 000 clocks per bit, the two frequencies are the 5th and 6th harmonics of a 60 µs window, and the line rate is 2 kbit/s.

A new peak and a new duty word take effect only at a carrier valley, so no switching cycle is cut short. A bit ends at the first valley after a full bit time has elapsed. The excess clocks carry into the next bit, which keeps the average bit rate exact. The two gate outputs are complementary, with a dead band in which both are off.

The frame machine has four states. IDLE sends 1 and moves to START when a byte is accepted at a valley. START sends 0 and moves to DATA on a bit tick. DATA sends the current data bit, shifts on each tick, and moves to STOP after the last bit. STOP sends 1 and returns to IDLE on its tick. Dropping the enable takes any state to IDLE.

Top module: `fskpwm_mod`

## Requirements
- R1: While reset is applied and enable is low, both gates, busy, in_ready and valley read 0.
- R2: With enable high and no frame in progress, the counter runs 0 up to PEAK_NOM and back to 0, giving a period of 2*PEAK_NOM clocks. The valley output is high for exactly the one clock per period in which the counter is 0.
- R3: The threshold is T = floor(duty*P / 2^DUTY_W), where P is the peak in use, and the main switch is requested while the counter is below T. In steady state, per period, gate_main is high for max(0, 2T-1-DEAD) clocks. gate_sync is high for 2P clocks when T = 0, and otherwise for max(0, 2P-2T+1-DEAD) clocks.
- R4: gate_main and gate_sync are never high together. After a change of the request, each gate stays off for DEAD clocks.
- R5: A duty word that changes in the middle of a carrier period does not alter that period. The new duty and the new peak are loaded only at a valley.
- R6: A frame is a 0 start bit, then DATA_BITS data bits with the least significant bit first, then a 1 stop bit. A 1 bit or idle runs periods of 2*PEAK_NOM clocks. A 0 bit runs periods of 2*PEAK_SHIFT clocks.
- R7: A bit ends at the first valley at which at least BIT_CLKS clocks have elapsed since the previous bit boundary plus the excess carried from it. The new excess is the elapsed count minus BIT_CLKS.
- R8: in_ready is high only at a valley while enabled and idle. A byte is taken when in_valid and in_ready are both high. busy is high from the cycle after acceptance until the cycle after the stop bit's final valley.
- R9: Enable low turns both gates off in the same cycle and returns the frame machine to idle on the next clock. After enable returns, the carrier restarts from a valley at the nominal period.
- R10: During 0 bits the threshold is recomputed from the same duty word with PEAK_SHIFT, so the gate counts follow R3 with P = PEAK_SHIFT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Enable for the modulator and the gates |
| duty | input | DUTY_W | Duty word, a fraction of 2^DUTY_W |
| in_data | input | DATA_BITS | Byte to send |
| in_valid | input | 1 | in_data is valid |
| in_ready | output | 1 | Byte accepted this cycle if in_valid is high |
| busy | output | 1 | A frame is in progress |
| gate_main | output | 1 | Main switch drive |
| gate_sync | output | 1 | Synchronous switch drive |
| valley | output | 1 | Carrier is at zero this cycle |

## Verification
A wrong peak register or a wrong frame state shows up at the next valley as a wrong spacing between valley strobes, one carrier period after the fault. The bench decodes the whole frame from those spacings. A wrong bit timer or a lost remainder changes the number of periods in a bit, so the error appears at the end of that bit. A bad threshold or a bad dead-time count changes the number of gate-high clocks within the same period. Each window is compared against the R3 arithmetic for every duty code and for both peaks.

// File: rtl/fskpwm_pkg.sv
package fskpwm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } frame_state_t;
endpackage

// File: rtl/fsk_tri_carrier.sv
module fsk_tri_carrier #(
    parameter int PEAK_NOM   = 300,
    parameter int PEAK_SHIFT = 360,
    parameter int DUTY_W     = 10,
    parameter int CW         = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              line_bit_nxt,
    input  logic [DUTY_W-1:0] duty,
    output logic              valley,
    output logic              req,
    output logic [CW-1:0]     peak_cur,
    output logic [CW-1:0]     thr_cur
);
    logic [CW-1:0]        cnt;
    logic                 up;
    logic [CW-1:0]        peak_sel;
    logic [DUTY_W+CW-1:0] prod;

    assign peak_sel = line_bit_nxt ? CW'(PEAK_NOM) : CW'(PEAK_SHIFT);
    assign prod     = {{CW{1'b0}}, duty} * {{DUTY_W{1'b0}}, peak_sel};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            up       <= 1'b1;
            peak_cur <= CW'(PEAK_NOM);
            thr_cur  <= '0;
        end else if (!en) begin
            cnt      <= '0;
            up       <= 1'b1;
            peak_cur <= CW'(PEAK_NOM);
            thr_cur  <= '0;
        end else begin
            if (cnt == '0) begin
                peak_cur <= peak_sel;
                thr_cur  <= prod[DUTY_W +: CW];
            end
            if (up) begin
                cnt <= cnt + CW'(1);
                if (cnt == peak_cur - CW'(1)) up <= 1'b0;
            end else begin
                cnt <= cnt - CW'(1);
                if (cnt == CW'(1)) up <= 1'b1;
            end
        end
    end

    assign valley = en && (cnt == '0);
    assign req    = cnt < thr_cur;
endmodule

// File: rtl/fsk_bit_timer.sv
module fsk_bit_timer #(
    parameter int BIT_CLKS = 30000,
    parameter int PEAK_MAX = 360
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic start,
    input  logic active,
    input  logic valley,
    output logic tick
);
    localparam int AW = $clog2(BIT_CLKS + 2 * PEAK_MAX + 1);
    logic [AW-1:0] acc;

    assign tick = active && valley && (acc >= AW'(BIT_CLKS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      acc <= '0;
        else if (!en)    acc <= '0;
        else if (start)  acc <= AW'(1);
        else if (tick)   acc <= acc - AW'(BIT_CLKS) + AW'(1);
        else if (active) acc <= acc + AW'(1);
    end
endmodule

// File: rtl/fsk_frame_fsm.sv
module fsk_frame_fsm
    import fskpwm_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 valley,
    input  logic                 tick,
    input  logic                 in_valid,
    input  logic [DATA_BITS-1:0] in_data,
    output logic                 in_ready,
    output logic                 busy,
    output logic                 start,
    output logic                 line_bit_nxt
);
    localparam int IW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [IW-1:0] LAST = IW'(DATA_BITS - 1);

    frame_state_t         state, nxt_state;
    logic [DATA_BITS-1:0] sh, nxt_sh;
    logic [IW-1:0]        idx, nxt_idx;
    logic                 accept;

    assign accept = en && valley && (state == ST_IDLE) && in_valid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            sh    <= '0;
            idx   <= '0;
        end else begin
            state <= nxt_state;
            sh    <= nxt_sh;
            idx   <= nxt_idx;
        end
    end

    always_comb begin
        nxt_state = state;
        nxt_sh    = sh;
        nxt_idx   = idx;
        unique case (state)
            ST_IDLE: if (accept) begin
                nxt_state = ST_START;
                nxt_sh    = in_data;
            end
            ST_START: if (tick) begin
                nxt_state = ST_DATA;
                nxt_idx   = '0;
            end
            ST_DATA: if (tick) begin
                nxt_sh = sh >> 1;
                if (idx == LAST) nxt_state = ST_STOP;
                else             nxt_idx   = idx + IW'(1);
            end
            ST_STOP: if (tick) nxt_state = ST_IDLE;
        endcase
        if (!en) nxt_state = ST_IDLE;
    end

    always_comb begin
        in_ready = en && valley && (state == ST_IDLE);
        busy     = state != ST_IDLE;
        start    = accept;
        unique case (nxt_state)
            ST_START: line_bit_nxt = 1'b0;
            ST_DATA:  line_bit_nxt = nxt_sh[0];
            default:  line_bit_nxt = 1'b1;
        endcase
    end
endmodule

// File: rtl/fsk_dead_band.sv
module fsk_dead_band #(
    parameter int DEAD = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic req,
    output logic gate_main,
    output logic gate_sync
);
    generate
        if (DEAD == 0) begin : g_nodead
            logic r_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r_q <= 1'b0;
                else        r_q <= en && req;
            end
            assign gate_main = en && r_q;
            assign gate_sync = en && !r_q;
        end else begin : g_dead
            localparam int DCW = $clog2(DEAD + 1);
            logic           r_q;
            logic [DCW-1:0] dcnt;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    r_q  <= 1'b0;
                    dcnt <= '0;
                end else if (!en) begin
                    r_q  <= 1'b0;
                    dcnt <= '0;
                end else begin
                    r_q <= req;
                    if (req != r_q)               dcnt <= '0;
                    else if (dcnt != DCW'(DEAD))  dcnt <= dcnt + DCW'(1);
                end
            end
            assign gate_main = en && r_q && (dcnt == DCW'(DEAD));
            assign gate_sync = en && !r_q && (dcnt == DCW'(DEAD));
        end
    endgenerate
endmodule

// File: rtl/fskpwm_mod.sv
module fskpwm_mod #(
    parameter int PEAK_NOM   = 300,
    parameter int PEAK_SHIFT = 360,
    parameter int BIT_CLKS   = 30000,
    parameter int DEAD       = 30,
    parameter int DUTY_W     = 10,
    parameter int DATA_BITS  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [DUTY_W-1:0]    duty,
    input  logic [DATA_BITS-1:0] in_data,
    input  logic                 in_valid,
    output logic                 in_ready,
    output logic                 busy,
    output logic                 gate_main,
    output logic                 gate_sync,
    output logic                 valley
);
    localparam int PEAK_MAX = (PEAK_NOM > PEAK_SHIFT) ? PEAK_NOM : PEAK_SHIFT;
    localparam int CW       = $clog2(PEAK_MAX + 1);

    logic          line_bit_nxt, req, tick, start;
    logic [CW-1:0] peak_cur, thr_cur;

    fsk_tri_carrier #(
        .PEAK_NOM(PEAK_NOM), .PEAK_SHIFT(PEAK_SHIFT), .DUTY_W(DUTY_W), .CW(CW)
    ) u_car (
        .clk(clk), .rst_n(rst_n), .en(en), .line_bit_nxt(line_bit_nxt),
        .duty(duty), .valley(valley), .req(req),
        .peak_cur(peak_cur), .thr_cur(thr_cur)
    );

    fsk_bit_timer #(.BIT_CLKS(BIT_CLKS), .PEAK_MAX(PEAK_MAX)) u_tmr (
        .clk(clk), .rst_n(rst_n), .en(en), .start(start),
        .active(busy), .valley(valley), .tick(tick)
    );

    fsk_frame_fsm #(.DATA_BITS(DATA_BITS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en), .valley(valley), .tick(tick),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .busy(busy), .start(start), .line_bit_nxt(line_bit_nxt)
    );

    fsk_dead_band #(.DEAD(DEAD)) u_db (
        .clk(clk), .rst_n(rst_n), .en(en), .req(req),
        .gate_main(gate_main), .gate_sync(gate_sync)
    );
endmodule

// File: rtl/fskpwm_chk.sv
module fskpwm_chk #(
    parameter int PEAK_NOM   = 300,
    parameter int PEAK_SHIFT = 360,
    parameter int DEAD       = 30,
    parameter int CW         = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          in_valid,
    input logic          in_ready,
    input logic          busy,
    input logic          gate_main,
    input logic          gate_sync,
    input logic          valley,
    input logic [CW-1:0] peak_cur,
    input logic [CW-1:0] thr_cur
);
    // R4
    gates_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_main && gate_sync));
    // R4
    main_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (DEAD > 0 && $rose(gate_main)) |-> !$past(gate_sync));
    // R4
    sync_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (DEAD > 0 && $rose(gate_sync)) |-> !$past(gate_main));
    // R9
    off_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (!gate_main && !gate_sync));
    // R9
    idle_after_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !busy);
    // R8
    ready_at_valley_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (valley && !busy && en));
    // R8
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(in_valid && in_ready));
    // R5
    peak_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !valley) |=> (!en || $stable(peak_cur)));
    // R5
    thr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !valley) |=> (!en || $stable(thr_cur)));
    // R6
    peak_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (peak_cur == CW'(PEAK_NOM)) || (peak_cur == CW'(PEAK_SHIFT)));
endmodule

bind fskpwm_mod fskpwm_chk #(
    .PEAK_NOM(PEAK_NOM), .PEAK_SHIFT(PEAK_SHIFT), .DEAD(DEAD), .CW(CW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .in_valid(in_valid), .in_ready(in_ready),
    .busy(busy), .gate_main(gate_main), .gate_sync(gate_sync), .valley(valley),
    .peak_cur(peak_cur), .thr_cur(thr_cur)
);

// File: tb/tb_fskpwm_mod.sv
`timescale 1ns/1ps
module tb_fskpwm_mod;
    localparam int PN   = 5;
    localparam int PS   = 6;
    localparam int BITC = 40;
    localparam int DT   = 1;
    localparam int DW   = 4;

    logic          clk = 1'b0;
    logic          rst_n, en, in_valid;
    logic [DW-1:0] duty;
    logic [7:0]    in_data;
    logic          in_ready, busy, gate_main, gate_sync, valley;

    int checks = 0;
    int fails  = 0;
    int overlap = 0;

    always #2.5 clk = ~clk;

    fskpwm_mod #(
        .PEAK_NOM(PN), .PEAK_SHIFT(PS), .BIT_CLKS(BITC), .DEAD(DT),
        .DUTY_W(DW), .DATA_BITS(8)
    ) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .duty(duty), .in_data(in_data),
        .in_valid(in_valid), .in_ready(in_ready), .busy(busy),
        .gate_main(gate_main), .gate_sync(gate_sync), .valley(valley)
    );

    always @(negedge clk) if (gate_main && gate_sync) overlap++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    function automatic int thr_of(input int p, input int d);
        return (d * p) >> DW;
    endfunction
    function automatic int exp_main(input int p, input int d);
        int t = thr_of(p, d);
        if (t == 0) return 0;
        return (2*t - 1 - DT > 0) ? 2*t - 1 - DT : 0;
    endfunction
    function automatic int exp_sync(input int p, input int d);
        int t = thr_of(p, d);
        if (t == 0) return 2*p;
        return (2*p - 2*t + 1 - DT > 0) ? 2*p - 2*t + 1 - DT : 0;
    endfunction

    // starts at a valley cycle, returns at the next valley cycle
    task automatic win(output int len, output int mh, output int sh);
        len = 0; mh = 0; sh = 0;
        do begin
            mh += int'(gate_main);
            sh += int'(gate_sync);
            len++;
            @(negedge clk);
            in_valid = 1'b0;
        end while (!valley);
    endtask

    task automatic send_frame(input int b);
        int rem, e, len, mh, sh, p, prev;
        bit bv;
        in_data  = 8'(b);
        in_valid = 1'b1;
        while (!(valley && in_ready)) @(negedge clk);
        chk(busy == 1'b0, "R8 idle before accept", int'(busy), 0);
        rem = 0; prev = 2*PN;
        for (int i = 0; i < 10; i++) begin
            if (i == 0)      bv = 1'b0;
            else if (i == 9) bv = 1'b1;
            else             bv = b[i-1];
            p = bv ? PN : PS;
            e = rem;
            do begin
                e += 2*p;
                win(len, mh, sh);
                chk(len == 2*p, "R6 R7 period", len, 2*p);
                if (prev == 2*p && len == 2*p) begin
                    chk(mh == exp_main(p, int'(duty)), "R10 main count", mh, exp_main(p, int'(duty)));
                    chk(sh == exp_sync(p, int'(duty)), "R10 sync count", sh, exp_sync(p, int'(duty)));
                end
                prev = len;
                chk(busy == 1'b1 && in_ready == 1'b0, "R8 busy in frame", int'(busy), 1);
            end while (e < BITC);
            rem = e - BITC;
        end
        @(negedge clk);
        chk(busy == 1'b0, "R8 busy after stop", int'(busy), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
    end

    initial begin
        int len, mh, sh;
        rst_n = 1'b0; en = 1'b0; duty = '0; in_valid = 1'b0; in_data = '0;
        repeat (3) @(negedge clk);
        // R1
        chk({gate_main, gate_sync, busy, in_ready, valley} == 5'b0, "R1 reset outputs",
            int'({gate_main, gate_sync, busy, in_ready, valley}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({gate_main, gate_sync, busy, in_ready, valley} == 5'b0, "R1 disabled outputs",
            int'({gate_main, gate_sync, busy, in_ready, valley}), 0);

        en = 1'b1; #1;
        while (!valley) @(negedge clk);
        chk(in_ready == 1'b1, "R8 ready at idle valley", int'(in_ready), 1);
        win(len, mh, sh);
        win(len, mh, sh);
        chk(len == 2*PN, "R2 idle period", len, 2*PN);
        @(negedge clk);
        chk(valley == 1'b0 && in_ready == 1'b0, "R2 R8 no strobe off valley", int'(valley), 0);
        while (!valley) @(negedge clk);

        // R3 sweep every duty code at the nominal peak
        for (int d = 0; d < (1 << DW); d++) begin
            duty = DW'(d);
            win(len, mh, sh);
            win(len, mh, sh);
            win(len, mh, sh);
            chk(len == 2*PN, "R2 period in sweep", len, 2*PN);
            chk(mh == exp_main(PN, d), "R3 main count", mh, exp_main(PN, d));
            chk(sh == exp_sync(PN, d), "R3 sync count", sh, exp_sync(PN, d));
        end

        // R5 mid-period duty change leaves the current period alone
        mh = int'(gate_main); sh = int'(gate_sync); len = 1;
        @(negedge clk);
        duty = '0;
        while (!valley) begin
            mh += int'(gate_main); sh += int'(gate_sync); len++;
            @(negedge clk);
        end
        chk(mh == exp_main(PN, 15), "R5 main holds old duty", mh, exp_main(PN, 15));
        chk(sh == exp_sync(PN, 15), "R5 sync holds old duty", sh, exp_sync(PN, 15));
        win(len, mh, sh);
        win(len, mh, sh);
        chk(mh == exp_main(PN, 0) && sh == exp_sync(PN, 0), "R5 new duty applied", sh, exp_sync(PN, 0));

        // R6 R7 R10 every byte value
        duty = DW'(8);
        for (int b = 0; b < 256; b++) send_frame(b);

        // R9 disable in the middle of a frame
        in_data = 8'h0F; in_valid = 1'b1;
        while (!(valley && in_ready)) @(negedge clk);
        win(len, mh, sh);
        repeat (3) @(negedge clk);
        en = 1'b0; #1;
        chk(gate_main == 1'b0 && gate_sync == 1'b0, "R9 gates off", int'(gate_main | gate_sync), 0);
        chk(in_ready == 1'b0 && valley == 1'b0, "R9 no ready", int'(in_ready), 0);
        @(negedge clk);
        chk(busy == 1'b0, "R9 frame dropped", int'(busy), 1'b0);
        en = 1'b1; #1;
        while (!valley) @(negedge clk);
        chk(in_ready == 1'b1, "R9 idle after restart", int'(in_ready), 1);
        win(len, mh, sh);
        chk(len == 2*PN, "R9 nominal after restart", len, 2*PN);

        chk(overlap == 0, "R4 gates never overlap", overlap, 0);
        summary();
    end
endmodule